// File: doc/BRIEF.md
# Coprocessor Slave Bus Interface

This block is the clocked slave side of a coprocessor's connection to a host CPU over a 16-bit data bus. The host opens a bus cycle by pulling address strobe and chip select low together at a rising clock edge and gives the direction on a write line. The block then leaves idle for a response state. In that state it either drives the selected data word onto the bus or takes in the word the host presents. It signals that it can finish through an active-low ready-out, and it goes back to idle when it samples the host's active-low ready input.

Operands of four or eight bytes move as a series of separate 16-bit cycles. A small bank of plain data registers, selected by an address captured at the start of the cycle, stands in for the arithmetic core and its operand queues.

A read always takes at least three clocks. The block drives the bus from the first clock of the response state, but it holds ready-out off for that first clock, so a host that wires ready-out back to its ready input gets exactly one wait state. A write may complete one clock earlier. On the edge where the block returns to idle, the output enable drops and the bus is released. The clock in which the block sits idle can already be the first clock of the next cycle.

Top module: `cpbus_slave`

## Requirements
- R1: After reset the block is idle, with `rdata_oe` = 0 and `ready_n` = 1, and every data register holds zero.
- R2: A cycle starts only at a rising edge where `strobe_n` = 0 and `sel_n` = 0. Strobe alone or select alone leaves the block idle, with `ready_n` = 1 and `rdata_oe` = 0, and changes no register.
- R3: For a read (`write` = 0), the clock after the start edge has `rdata_oe` = 1 and `ready_n` = 1 (one wait state). The clock after that has `ready_n` = 0 with `rdata_oe` still 1.
- R4: A read whose host ready arrives at the earliest edge lasts exactly three clocks. `rdata_oe` returns to 0 and `ready_n` to 1 on the edge that samples `host_rdy_n` = 0.
- R5: Once `ready_n` is asserted, it stays 0 (and `rdata_oe` stays unchanged) until an edge samples `host_rdy_n` = 0, so the host can add any number of extra wait states.
- R6: `host_rdy_n` = 0 during the forced wait clock of a read is ignored, and the cycle still runs into its ready clock.
- R7: For a write (`write` = 1), `ready_n` = 0 from the clock after the start edge, and `rdata_oe` stays 0 throughout. `wdata` is stored into the register selected by the captured address at the edge that samples `host_rdy_n` = 0.
- R8: The host may start a new cycle in the very clock in which the block has returned to idle, with no dead clock between cycles.
- R9: Read data on `rdata` equals the register selected by `addr` as captured at the start edge, even if `addr` changes later in the cycle.
- R10: While idle, `rdata_oe` = 0 and `ready_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Active-low address strobe from the host |
| sel_n | input | 1 | Active-low chip select |
| write | input | 1 | Cycle direction: 1 write, 0 read |
| host_rdy_n | input | 1 | Active-low ready as seen by the host |
| addr | input | ADDR_W (2) | Register select, captured at cycle start |
| wdata | input | DATA_W (16) | Write data from the host |
| rdata | output | DATA_W (16) | Read data, zero while not driven |
| rdata_oe | output | 1 | Output enable for the data bus drivers |
| ready_n | output | 1 | Active-low ready-out |

## Verification
The properties assume that the host starts a cycle only from idle and lowers `host_rdy_n` in a way that completion requires a clock in which `ready_n` is already low. They rebuild the busy/idle view from the ports alone, without looking inside the design. The directed tasks drive every input at the falling edge. They open a new cycle only at a clock the previous task has confirmed idle, and they release `host_rdy_n` right after the completing edge. An early ready is shown only inside the forced wait clock of a read, where it must be ignored.

// File: rtl/cpbus_pkg.sv
package cpbus_pkg;
   typedef enum logic [1:0] {
      CP_IDLE  = 2'd0,
      CP_WAIT  = 2'd1,
      CP_READY = 2'd2
   } cp_state_e;
endpackage

// File: rtl/cpbus_fsm.sv
module cpbus_fsm
   import cpbus_pkg::*;
#(
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_n,
   input  logic              sel_n,
   input  logic              write,
   input  logic              host_rdy_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] cyc_addr,
   output logic              commit,
   output logic              drive_oe,
   output logic              ready_n
);
   cp_state_e         state_q, state_d;
   logic              cyc_wr_q;
   logic [ADDR_W-1:0] cyc_addr_q;
   logic              start;

   assign start = !strobe_n && !sel_n;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         CP_IDLE:  if (start) state_d = write ? CP_READY : CP_WAIT;
         CP_WAIT:  state_d = CP_READY;
         CP_READY: if (!host_rdy_n) state_d = CP_IDLE;
         default:  state_d = CP_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= CP_IDLE;
         cyc_wr_q   <= 1'b0;
         cyc_addr_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == CP_IDLE && start) begin
            cyc_wr_q   <= write;
            cyc_addr_q <= addr;
         end
      end
   end

   assign cyc_addr = cyc_addr_q;
   assign ready_n  = (state_q != CP_READY);
   assign drive_oe = (state_q != CP_IDLE) && !cyc_wr_q;
   assign commit   = (state_q == CP_READY) && cyc_wr_q && !host_rdy_n;
endmodule

// File: rtl/cpbus_regbank.sv
module cpbus_regbank #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DEPTH-1:0][DATA_W-1:0] words;

   for (genvar g = 0; g < DEPTH; g++) begin : g_word
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= '0;
         else if (wr_en && sel == ADDR_W'(g))      q <= wr_data;
      end
      assign words[g] = q;
   end

   assign rd_data = words[sel];
endmodule

// File: rtl/cpbus_slave.sv
module cpbus_slave #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_n,
   input  logic              sel_n,
   input  logic              write,
   input  logic              host_rdy_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              rdata_oe,
   output logic              ready_n
);
   if (DATA_W < 8 || DATA_W % 8 != 0) begin : g_bad_width
      $error("cpbus_slave: DATA_W must be a whole number of bytes");
   end
   if (ADDR_W < 1 || ADDR_W > 6) begin : g_bad_addr
      $error("cpbus_slave: ADDR_W must lie in 1..6");
   end

   logic [ADDR_W-1:0] cyc_addr;
   logic              commit;
   logic              drive_oe;
   logic [DATA_W-1:0] word;

   cpbus_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .strobe_n  (strobe_n),
      .sel_n     (sel_n),
      .write     (write),
      .host_rdy_n(host_rdy_n),
      .addr      (addr),
      .cyc_addr  (cyc_addr),
      .commit    (commit),
      .drive_oe  (drive_oe),
      .ready_n   (ready_n)
   );

   cpbus_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (commit),
      .sel    (cyc_addr),
      .wr_data(wdata),
      .rd_data(word)
   );

   assign rdata_oe = drive_oe;
   assign rdata    = drive_oe ? word : '0;
endmodule

// File: rtl/cpbus_slave_chk.sv
module cpbus_slave_chk (
   input logic clk,
   input logic rst_n,
   input logic strobe_n,
   input logic sel_n,
   input logic write,
   input logic host_rdy_n,
   input logic rdata_oe,
   input logic ready_n
);
   logic busy;
   logic begin_cyc;

   assign begin_cyc = !busy && !strobe_n && !sel_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         busy <= 1'b0;
      else if (begin_cyc)                 busy <= 1'b1;
      else if (!ready_n && !host_rdy_n)   busy <= 1'b0;
   end

   // R10: idle means bus released and not ready
   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!rdata_oe && ready_n));

   // R3: read opens with bus driven and ready held off
   assert_read_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (begin_cyc && !write) |=> (rdata_oe && ready_n));

   // R3: the forced wait lasts one clock only
   assert_one_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rdata_oe && ready_n) |=> (!ready_n && rdata_oe));

   // R7: writes are ready at once and never drive the bus
   assert_write_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (begin_cyc && write) |=> (!ready_n && !rdata_oe));

   // R5: ready-out is held until the host completes
   assert_ready_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ready_n && host_rdy_n) |=> (!ready_n && $stable(rdata_oe)));

   // R4: completion releases the bus on the same edge
   assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ready_n && !host_rdy_n) |=> (!rdata_oe && ready_n));

   // R2: no cycle without both strobe and select
   assert_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (strobe_n || sel_n)) |=> (ready_n && !rdata_oe));
endmodule

bind cpbus_slave cpbus_slave_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .strobe_n  (strobe_n),
   .sel_n     (sel_n),
   .write     (write),
   .host_rdy_n(host_rdy_n),
   .rdata_oe  (rdata_oe),
   .ready_n   (ready_n)
);

// File: tb/cpbus_slave_tb.sv
module cpbus_slave_tb;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 2;
   localparam int DEPTH  = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              strobe_n = 1'b1;
   logic              sel_n = 1'b1;
   logic              write = 1'b0;
   logic              host_rdy_n = 1'b1;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;
   logic              rdata_oe;
   logic              ready_n;

   int n_checks = 0;
   int n_errors = 0;
   logic [DATA_W-1:0] model [DEPTH];

   always #10 clk = ~clk;

   cpbus_slave #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .sel_n(sel_n),
      .write(write), .host_rdy_n(host_rdy_n), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rdata_oe(rdata_oe), .ready_n(ready_n)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      check(req, "rdata_oe idle", 32'(rdata_oe), 32'd0);
      check(req, "ready_n idle", 32'(ready_n), 32'd1);
   endtask

   // read cycle; starts at a falling edge with the block idle
   task automatic rd_cycle(input logic [ADDR_W-1:0] a, input int extra,
                           input bit early, input string tag);
      strobe_n = 1'b0; sel_n = 1'b0; write = 1'b0; addr = a;
      @(negedge clk);
      strobe_n = 1'b1; sel_n = 1'b1; addr = ~a;
      check("R3", "oe in wait clock", 32'(rdata_oe), 32'd1);
      check("R3", "ready_n in wait clock", 32'(ready_n), 32'd1);
      check(tag, "read data", 32'(rdata), 32'(model[a]));
      host_rdy_n = early ? 1'b0 : 1'b1;
      @(negedge clk);
      check(early ? "R6" : "R3", "ready_n after wait", 32'(ready_n), 32'd0);
      check(early ? "R6" : "R3", "oe after wait", 32'(rdata_oe), 32'd1);
      host_rdy_n = (extra > 0) ? 1'b1 : 1'b0;
      for (int i = 0; i < extra; i++) begin
         @(negedge clk);
         check("R5", "ready_n held", 32'(ready_n), 32'd0);
         check("R5", "oe held", 32'(rdata_oe), 32'd1);
         check("R9", "data held", 32'(rdata), 32'(model[a]));
         if (i == extra - 1) host_rdy_n = 1'b0;
      end
      @(negedge clk);
      host_rdy_n = 1'b1;
      check_idle("R4");
   endtask

   task automatic wr_cycle(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                           input int extra);
      strobe_n = 1'b0; sel_n = 1'b0; write = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      strobe_n = 1'b1; sel_n = 1'b1; addr = ~a;
      check("R7", "ready_n first clock", 32'(ready_n), 32'd0);
      check("R7", "oe stays low", 32'(rdata_oe), 32'd0);
      host_rdy_n = (extra > 0) ? 1'b1 : 1'b0;
      for (int i = 0; i < extra; i++) begin
         @(negedge clk);
         check("R5", "write ready_n held", 32'(ready_n), 32'd0);
         check("R7", "write oe low", 32'(rdata_oe), 32'd0);
         if (i == extra - 1) host_rdy_n = 1'b0;
      end
      @(negedge clk);
      host_rdy_n = 1'b1; write = 1'b0; wdata = ~d;
      model[a] = d;
      check_idle("R8");
   endtask

   task automatic no_select(input logic [ADDR_W-1:0] a);
      strobe_n = 1'b0; sel_n = 1'b1; write = 1'b1; addr = a; wdata = 16'hBEEF;
      @(negedge clk);
      check_idle("R2");
      strobe_n = 1'b1; sel_n = 1'b0;
      @(negedge clk);
      check_idle("R2");
      sel_n = 1'b1; write = 1'b0;
      @(negedge clk);
      check_idle("R2");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
      repeat (3) @(negedge clk);
      check_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R10");
      rd_cycle(2'd2, 0, 1'b0, "R1");
      wr_cycle(2'd0, 16'h1234, 0);
      wr_cycle(2'd1, 16'hA5C3, 2);
      wr_cycle(2'd3, 16'hFFFF, 0);
      rd_cycle(2'd3, 0, 1'b0, "R8");
      rd_cycle(2'd1, 2, 1'b0, "R9");
      @(negedge clk);
      check_idle("R10");
      rd_cycle(2'd0, 1, 1'b1, "R6");
      no_select(2'd1);
      rd_cycle(2'd1, 0, 1'b0, "R2");
      wr_cycle(2'd2, 16'h0F0F, 1);
      rd_cycle(2'd2, 0, 1'b0, "R8");
      wr_cycle(2'd2, 16'h7001, 0);
      rd_cycle(2'd2, 0, 1'b0, "R7");
      rd_cycle(2'd3, 3, 1'b0, "R9");
      repeat (2) @(negedge clk);
      check_idle("R10");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule